// File: doc/BRIEF.md
# Paged External Data Memory Bus Master

This block moves single bytes between an 8051-style core and an external SRAM over a multiplexed bus with a 24-bit address space. The core hands it a request made of a page byte, a high address byte, a low address byte, a read or write command and, for writes, one data byte. The block then runs a fixed sequence of bus phases and reports the result with a one-cycle done pulse.

The low port is shared. It first carries the low address byte, which an external latch captures while the address latch enable is high, and then carries data. The upper port shows the page byte while the latch enable is high, so a second external latch can hold bits 23:16. It then switches to the high address byte for the rest of the access. A system without the page latch never sees the page byte, so it works as a plain 64K data space.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, and `busy` is its complement. A request offered while busy is not stored: the requester must hold it until `req_ready` returns. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse, and `rsp_rdata` is meaningful in that cycle for reads.

Top module: `xmem_pager`

## Requirements
- R1: A request is accepted only on a clock edge with `req_valid` and `req_ready` both high. `req_ready` is high exactly when the block is idle, and `busy` is always the inverse of `req_ready`.
- R2: In the first cycle after acceptance, `ale` is high for exactly one cycle. During that cycle `lo_out` carries address bits 7:0, `lo_oe` is high, and `hi_out` carries address bits 23:16 (the page byte).
- R3: From the second cycle after acceptance until the done cycle, `ale` stays low and `hi_out` carries address bits 15:8. In the second cycle, `lo_out` still carries address bits 7:0 with `lo_oe` high.
- R4: Exactly one of the active-low strobes (`rd_n` for a read, `wr_n` for a write) is low, for exactly STROBE_CYCLES consecutive cycles starting in the third cycle after acceptance. `rd_n` and `wr_n` are never low together, and neither is low while `ale` is high.
- R5: On a write, `lo_out` carries the write byte with `lo_oe` high for the whole strobe and for the single release cycle that follows it.
- R6: On a read, `lo_oe` is low for the whole strobe, the release cycle and the done cycle. `rsp_rdata` holds the `lo_in` value sampled on the last cycle of the strobe.
- R7: `rsp_valid` is high for one cycle. It rises STROBE_CYCLES+3 clock edges after the accepting edge, and `req_ready` is high again in the next cycle.
- R8: A request offered while `busy` is high has no effect: no address, data or strobe from it ever reaches the bus.
- R9: Because the page byte appears only while `ale` is high, a system that latches only the low byte and reads `hi_out` during the strobe sees a 16-bit address. Pages that differ only in bits 23:16 then alias to the same location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | {page, high, low} byte address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 8 | Read byte, valid with rsp_valid |
| lo_out | output | 8 | Low port drive value (address then data) |
| lo_oe | output | 1 | Low port drive enable |
| lo_in | input | 8 | Low port value driven by memory |
| hi_out | output | 8 | Upper port: page byte, then high byte |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bound checker watches every cycle for the following:
- the strobes never overlap and are never low while `ale` is high;
- `ale` is a single-cycle pulse that only follows an accepted request;
- the low port is released throughout a read strobe and in the cycle after it;
- every strobe lasts exactly STROBE_CYCLES cycles;
- the block is ready again right after the done pulse.

The bench's scenarios are the only way to show the remaining behaviour:
- addresses and data land in the right place through the bench's external latches;
- read data comes back;
- a request made while busy leaves memory untouched;
- pages alias when the page latch is absent.

// File: rtl/xmp_pkg.sv
package xmp_pkg;
  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_ADDR    = 3'd1,
    S_HOLD    = 3'd2,
    S_STROBE  = 3'd3,
    S_RELEASE = 3'd4,
    S_DONE    = 3'd5
  } xmp_state_e;
endpackage

// File: rtl/xmp_sequencer.sv
module xmp_sequencer
  import xmp_pkg::*;
#(
  parameter int STROBE_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output xmp_state_e state,
  output logic       last_strobe
);
  localparam int CNT_W = $clog2(STROBE_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  assign last_strobe = (state == S_STROBE) && (cnt == CNT_W'(STROBE_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE:    if (start) state <= S_ADDR;
        S_ADDR:    state <= S_HOLD;
        S_HOLD: begin
          state <= S_STROBE;
          cnt   <= '0;
        end
        S_STROBE: begin
          if (last_strobe) state <= S_RELEASE;
          else             cnt   <= cnt + 1'b1;
        end
        S_RELEASE: state <= S_DONE;
        S_DONE:    state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xmp_port_mux.sv
module xmp_port_mux
  import xmp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  xmp_state_e        state,
  input  logic              is_write,
  input  logic [BYTE_W-1:0] page_b,
  input  logic [BYTE_W-1:0] high_b,
  input  logic [BYTE_W-1:0] low_b,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo_out,
  output logic              lo_oe,
  output logic [BYTE_W-1:0] hi_out,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);
  always_comb begin
    lo_out = '0;
    lo_oe  = 1'b0;
    hi_out = '0;
    ale    = 1'b0;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    case (state)
      S_ADDR: begin
        ale    = 1'b1;
        lo_out = low_b;
        lo_oe  = 1'b1;
        hi_out = page_b;
      end
      S_HOLD: begin
        lo_out = low_b;
        lo_oe  = 1'b1;
        hi_out = high_b;
      end
      S_STROBE: begin
        hi_out = high_b;
        if (is_write) begin
          lo_out = wdata;
          lo_oe  = 1'b1;
          wr_n   = 1'b0;
        end else begin
          rd_n   = 1'b0;
        end
      end
      S_RELEASE: begin
        hi_out = high_b;
        if (is_write) begin
          lo_out = wdata;
          lo_oe  = 1'b1;
        end
      end
      S_DONE: hi_out = high_b;
      default: ;
    endcase
  end
endmodule

// File: rtl/xmp_read_capture.sv
module xmp_read_capture #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [BYTE_W-1:0] bus_in,
  output logic [BYTE_W-1:0] held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held <= '0;
    else if (sample) held <= bus_in;
  end
endmodule

// File: rtl/xmem_pager.sv
module xmem_pager
  import xmp_pkg::*;
#(
  parameter int BYTE_W        = 8,
  parameter int STROBE_CYCLES = 3,
  localparam int ADDR_W       = 3 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic [BYTE_W-1:0] lo_out,
  output logic              lo_oe,
  input  logic [BYTE_W-1:0] lo_in,
  output logic [BYTE_W-1:0] hi_out,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);
  xmp_state_e        state;
  logic              last_strobe;
  logic              take;
  logic              cur_write;
  logic [ADDR_W-1:0] cur_addr;
  logic [BYTE_W-1:0] cur_wdata;

  assign req_ready = (state == S_IDLE);
  assign busy      = !req_ready;
  assign take      = req_valid && req_ready;
  assign rsp_valid = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_write <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else if (take) begin
      cur_write <= req_write;
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
    end
  end

  xmp_sequencer #(.STROBE_CYCLES(STROBE_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (take),
    .state      (state),
    .last_strobe(last_strobe)
  );

  xmp_port_mux #(.BYTE_W(BYTE_W)) u_mux (
    .state   (state),
    .is_write(cur_write),
    .page_b  (cur_addr[3*BYTE_W-1:2*BYTE_W]),
    .high_b  (cur_addr[2*BYTE_W-1:BYTE_W]),
    .low_b   (cur_addr[BYTE_W-1:0]),
    .wdata   (cur_wdata),
    .lo_out  (lo_out),
    .lo_oe   (lo_oe),
    .hi_out  (hi_out),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n)
  );

  xmp_read_capture #(.BYTE_W(BYTE_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .sample(last_strobe && !cur_write),
    .bus_in(lo_in),
    .held  (rsp_rdata)
  );
endmodule

// File: rtl/xmem_pager_checker.sv
module xmem_pager_checker #(
  parameter int STROBE_CYCLES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic rsp_valid,
  input logic lo_oe,
  input logic ale,
  input logic rd_n,
  input logic wr_n
);
  localparam int RUN_W = $clog2(STROBE_CYCLES + 2);

  logic             strobe_on;
  logic [RUN_W-1:0] run;

  assign strobe_on = !rd_n || !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run <= '0;
    else if (strobe_on) run <= run + 1'b1;
    else                run <= '0;
  end

  p_ready_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy != req_ready);

  p_ale_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> $past(req_valid && req_ready));

  p_ale_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_no_strobe_ale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));

  p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_on && run != '0) |-> (run == RUN_W'(STROBE_CYCLES)));

  p_read_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !lo_oe);

  p_release_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> !lo_oe);

  p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (req_ready && !rsp_valid));
endmodule

bind xmem_pager xmem_pager_checker #(.STROBE_CYCLES(STROBE_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .busy     (busy),
  .rsp_valid(rsp_valid),
  .lo_oe    (lo_oe),
  .ale      (ale),
  .rd_n     (rd_n),
  .wr_n     (wr_n)
);

// File: tb/xmem_pager_bench.sv
module xmem_pager_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSTB       = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [7:0]  lo_out;
  logic        lo_oe;
  logic [7:0]  lo_in;
  logic [7:0]  hi_out;
  logic        ale;
  logic        rd_n;
  logic        wr_n;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmem_pager #(.STROBE_CYCLES(NSTB)) u_xmem_pager (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in), .hi_out(hi_out),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  // External latches and SRAM model (index uses 2 page, 2 high, 4 low bits)
  bit         page_fit = 1'b1;
  logic [7:0] lat_lo = '0;
  logic [7:0] lat_pg = '0;
  logic [7:0] mem [256];
  logic [7:0] idx;

  function automatic logic [7:0] dflt(input int i);
    return 8'((i * 7) + 3);
  endfunction

  function automatic logic [7:0] pat(input int pg, input int hi, input int lo);
    return 8'((pg * 64) + (hi * 16) + lo) ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) if (ale) begin
    lat_lo <= lo_out;
    lat_pg <= hi_out;
  end

  assign idx   = {(page_fit ? lat_pg[1:0] : 2'b00), hi_out[1:0], lat_lo[3:0]};
  assign lo_in = (!rd_n) ? mem[idx] : 8'hEE;

  always @(posedge clk) if (!wr_n) mem[idx] <= lo_out;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int pg, input int hi, input int lo,
                        input logic [7:0] wd, input bit intrude,
                        output logic [7:0] rd);
    int cnt = 0;
    int stb = 0;
    @(negedge clk);
    chk(req_ready && !busy, "R1 ready when idle", {busy, req_ready}, 1);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {8'(pg), 8'(hi), 8'(lo)};
    req_wdata = wd;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        req_valid = 1'b0;
        chk(ale && lo_oe && lo_out == 8'(lo) && hi_out == 8'(pg), "R2 address phase",
            {ale, lo_oe, lo_out, hi_out}, {2'b11, 8'(lo), 8'(pg)});
      end
      if (cnt == 2)
        chk(!ale && lo_oe && lo_out == 8'(lo) && hi_out == 8'(hi), "R3 hold phase",
            {ale, lo_oe, lo_out, hi_out}, {2'b01, 8'(lo), 8'(hi)});
      if (cnt == 3) begin
        chk(hi_out == 8'(hi) && !ale, "R3 high byte in strobe", hi_out, hi);
        if (wr) chk(!wr_n && rd_n && lo_oe && lo_out == wd, "R5 write drive",
                    {wr_n, rd_n, lo_oe, lo_out}, {3'b011, wd});
        else    chk(!rd_n && wr_n && !lo_oe, "R6 read release",
                    {rd_n, wr_n, lo_oe}, 3'b010);
        if (intrude) begin
          chk(busy && !req_ready, "R1 busy during access", {busy, req_ready}, 2);
          req_valid = 1'b1;
          req_write = 1'b1;
          req_addr  = {8'd3, 8'd3, 8'd2};
          req_wdata = 8'hAA;
        end
      end
      if (cnt == 4) req_valid = 1'b0;
      if (!rd_n || !wr_n) stb++;
      if (cnt == NSTB + 3) begin
        if (wr) chk(lo_oe && lo_out == wd && wr_n, "R5 release hold", {lo_oe, lo_out}, {1'b1, wd});
        else    chk(!lo_oe && rd_n, "R6 release float", lo_oe, 0);
      end
    end while (!rsp_valid && cnt < 40);
    chk(cnt == NSTB + 4, "R7 done latency", cnt, NSTB + 4);
    chk(stb == NSTB, "R4 strobe width", stb, NSTB);
    if (!wr) chk(!lo_oe, "R6 done float", lo_oe, 0);
    rd = rsp_rdata;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R7 single pulse then ready", {rsp_valid, req_ready}, 1);
  endtask

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 256; i++) mem[i] = dflt(i);
    repeat (3) @(negedge clk);
    chk(req_ready && !busy && !rsp_valid && !ale && rd_n && wr_n && !lo_oe, "R1 reset state",
        {req_ready, busy, rsp_valid, ale, rd_n, wr_n, lo_oe}, 7'b1000110);
    rst_n = 1'b1;

    // R2 R5: write sweep over pages, high bytes and low bytes
    for (int pg = 0; pg < 4; pg++)
      for (int hi = 0; hi < 4; hi++)
        for (int lo = 0; lo < 16; lo += 5)
          access(1'b1, pg, hi, lo, pat(pg, hi, lo), (pg == 1 && hi == 2 && lo == 5), r);

    // R6: read back the full sweep
    for (int pg = 0; pg < 4; pg++)
      for (int hi = 0; hi < 4; hi++)
        for (int lo = 0; lo < 16; lo += 5) begin
          access(1'b0, pg, hi, lo, 8'h00, (pg == 2 && hi == 0 && lo == 10), r);
          chk(r == pat(pg, hi, lo), "R6 read data", r, pat(pg, hi, lo));
        end

    // R6: unwritten locations return their initial contents
    for (int lo = 1; lo < 16; lo += 5) begin
      access(1'b0, 2, 3, lo, 8'h00, 1'b0, r);
      chk(r == dflt(128 + 48 + lo), "R6 unwritten read", r, dflt(128 + 48 + lo));
    end

    // R8: the intruding write to page 3, high 3, low 2 must not have landed
    access(1'b0, 3, 3, 2, 8'h00, 1'b0, r);
    chk(r == dflt(192 + 48 + 2), "R8 request while busy ignored", r, dflt(242));

    // R9: without a page latch, pages alias
    page_fit = 1'b0;
    access(1'b1, 2, 1, 3, 8'h3C, 1'b0, r);
    access(1'b0, 0, 1, 3, 8'h00, 1'b0, r);
    chk(r == 8'h3C, "R9 page ignored without latch", r, 8'h3C);
    access(1'b0, 3, 1, 3, 8'h00, 1'b0, r);
    chk(r == 8'h3C, "R9 other page aliases", r, 8'h3C);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule